// File: doc/BRIEF.md
# SPI Transmit Queue Controller

This block holds the outgoing command/data words of an SPI controller. A host processor or a DMA engine writes 32-bit entries through a push port, and the shift-register side takes them one at a time through a load strobe. The entry at the head of the queue is always presented on `load_data`, so the shift register samples it in the same cycle it raises `load_req`. An occupancy count and a next-slot index are exported so software can see how many entries are waiting and which storage slot will be sent next.

Three sticky status flags are kept, and a write of 1 on each flag's clear strobe clears it. The space-available flag asks for more data and is also driven out as a request line that can feed either an interrupt or a DMA channel. The transfer-done flag marks the end of each shift. The underflow flag records that an outside master began a transfer while this block, acting as a slave, had nothing queued. A flush strobe empties the queue in one cycle.

The serializer, SPI clocking, receive path and register decoding sit outside the block. The shift register appears only as the `load_req` strobe and the `xfer_done` pulse.

Top module: `spi_txq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `level` 0, `next_slot` 0, `entry_avail` 0, `space_flag` 1, `done_flag` 0 and `underrun_flag` 0.
- R2: A push (`push_valid`=1) when `level` < 4 and `flush`=0 is accepted. After the edge, `level` is one higher. Entries later appear on `load_data` in the order they were pushed.
- R3: A load (`load_req`=1) when `level` > 0 and `flush`=0 removes the head entry. After the edge, `level` is one lower and `next_slot` is one higher, counted modulo 4 (3 wraps to 0). `entry_avail` is 1 exactly when `level` > 0.
- R4: A push when `level` = 4 is dropped. No change is made to `level`, `next_slot` or the stored entries, and no error is signalled.
- R5: A push and a load in the same cycle on a queue that is neither empty nor full leave `level` unchanged and advance `next_slot` by one.
- R6: A cycle with `flush`=1 makes `level` 0 and `next_slot` 0 after the edge. A push or load in that same cycle is discarded.
- R7: `space_flag` becomes 1 at any edge where `level` < 4, unless it is cleared at that edge. An accepted push with `push_from_dma`=1 that raises `level` to 4 clears it. A host push (`push_from_dma`=0) that fills the queue, or a dropped DMA push, leaves it at 1.
- R8: `space_clr`=1 clears `space_flag` at the next edge. While `level` = 4 the flag then stays 0. Once `level` < 4 it returns to 1 at the following edge. `space_req` always equals `space_flag`.
- R9: `xfer_done`=1 sets `done_flag` at the next edge. The flag stays set until `done_clr`=1. If set and clear come in the same cycle, the flag ends up set.
- R10: `underrun_flag` is set at the next edge when `slave_mode`=1, `ext_start`=1 and `level` = 0. It is not set in master mode (`slave_mode`=0) or when `level` > 0. It stays set until `underrun_clr`=1, and a set in the same cycle as the clear wins.
- R11: A load when `level` = 0 is ignored, and `level` and `next_slot` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Push strobe for `push_data` |
| push_from_dma | input | 1 | Marks the push as coming from the DMA engine |
| push_data | input | 32 | Entry to enqueue |
| load_req | input | 1 | Shift register takes the head entry |
| xfer_done | input | 1 | End-of-transfer pulse from the shift register |
| slave_mode | input | 1 | 1 when the controller acts as an SPI slave |
| ext_start | input | 1 | An outside master begins a transfer |
| flush | input | 1 | Empty the queue |
| space_clr | input | 1 | Write-1 clear of `space_flag` |
| done_clr | input | 1 | Write-1 clear of `done_flag` |
| underrun_clr | input | 1 | Write-1 clear of `underrun_flag` |
| load_data | output | 32 | Head entry, valid while `entry_avail` is 1 |
| entry_avail | output | 1 | Queue holds at least one entry |
| level | output | 3 | Number of valid entries, 0 to 4 |
| next_slot | output | 2 | Storage slot of the entry sent next |
| space_flag | output | 1 | Room-available flag |
| space_req | output | 1 | Interrupt or DMA request driven by `space_flag` |
| done_flag | output | 1 | Transfer-complete flag |
| underrun_flag | output | 1 | Slave underflow flag |

## Verification
Every registered result (`level`, `next_slot`, the three flags and `entry_avail`) is due one clock edge after the input that causes it. `load_data` follows combinationally from the stored head, so a pushed word can be read right after the edge that stores it. The bench drives inputs and samples 1 ns after each rising edge. It checks the registered outputs in that slot for the edge just taken, and it checks `load_data` in the same slot before the edge that performs the load. The space flag's re-arm after a clear is checked two edges out, matching its one-edge look at the current level.

// File: rtl/spi_txq_pkg.sv
// Package: shared sizes and the event type used by the sticky status flags.
// Assumes: queue depth is a power of two so pointers wrap naturally.
package spi_txq_pkg;
    localparam int TXQ_DATA_W = 32;
    localparam int TXQ_DEPTH  = 4;

    // Set/clear event pair for one write-1-to-clear flag
    typedef struct packed {
        logic set;
        logic clr;
    } flag_evt_t;
endpackage

// File: rtl/spi_txq_mem.sv
// Module: spi_txq_mem
// Entry storage of the transmit queue: one write port, one asynchronous read port.
// Assumes: the controller never writes and reads an invalid slot; storage holds no reset.
module spi_txq_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slots [DEPTH];

    // Store an accepted entry into its slot
    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_idx] <= wr_data;
    end

    // Present the head slot to the shift register
    always_comb rd_data = slots[rd_idx];
endmodule

// File: rtl/spi_txq_ptrs.sv
// Module: spi_txq_ptrs
// Write/read pointers and occupancy counter; decides which pushes and loads are accepted.
// Assumes: DEPTH is a power of two; flush has priority over push and load.
module spi_txq_ptrs #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             flush,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // Occupancy decode
    always_comb begin
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        push_ok = push_req && !full && !flush;
        pop_ok  = pop_req && !empty && !flush;
    end

    // Pointer and counter update; flush returns everything to slot 0
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_idx <= wr_idx + IDX_W'(1);
            if (pop_ok)  rd_idx <= rd_idx + IDX_W'(1);
            if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
            else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
        end
    end

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && full && !pop_req && !flush |=> $stable(count) && $stable(rd_idx) && $stable(wr_idx));

    // R3
    load_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !empty && !push_req && !flush
        |=> count == $past(count) - CNT_W'(1) && rd_idx == $past(rd_idx) + IDX_W'(1));

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0 && rd_idx == '0 && wr_idx == '0);

    // R11
    empty_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && empty && !push_req && !flush |=> count == '0 && $stable(rd_idx));
endmodule

// File: rtl/spi_txq_w1c_flag.sv
// Module: spi_txq_w1c_flag
// One sticky status bit: a set event raises it, a write-1 clear lowers it, set wins a tie.
// Assumes: set and clear are single-cycle strobes sampled on the clock edge.
module spi_txq_w1c_flag (
    input  logic clk,
    input  logic rst_n,
    input  spi_txq_pkg::flag_evt_t evt,
    output logic flag
);
    // Sticky update with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (evt.set) flag <= 1'b1;
        else if (evt.clr) flag <= 1'b0;
    end

    // R9 R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.set |=> flag);

    // R9 R10
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.clr && !evt.set |=> !flag);

    // R9 R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !evt.clr |=> flag);
endmodule

// File: rtl/spi_txq_ctrl.sv
// Module: spi_txq_ctrl
// Transmit queue controller for an SPI master/slave: push port, head presentation to the
// shift register, occupancy/next-slot status, space/done/underrun flags with write-1 clear.
// Assumes: single clock domain; all strobes are one cycle wide; synchronous active-low reset.
module spi_txq_ctrl #(
    parameter int DATA_W = spi_txq_pkg::TXQ_DATA_W,
    parameter int DEPTH  = spi_txq_pkg::TXQ_DEPTH,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic              push_from_dma,
    input  logic [DATA_W-1:0] push_data,
    input  logic              load_req,
    input  logic              xfer_done,
    input  logic              slave_mode,
    input  logic              ext_start,
    input  logic              flush,
    input  logic              space_clr,
    input  logic              done_clr,
    input  logic              underrun_clr,
    output logic [DATA_W-1:0] load_data,
    output logic              entry_avail,
    output logic [CNT_W-1:0]  level,
    output logic [IDX_W-1:0]  next_slot,
    output logic              space_flag,
    output logic              space_req,
    output logic              done_flag,
    output logic              underrun_flag
);
    import spi_txq_pkg::*;

    localparam int N_STICKY = 2;
    localparam logic [CNT_W-1:0] LAST_FREE = CNT_W'(DEPTH - 1);

    logic             push_ok, pop_ok, full, empty;
    logic [IDX_W-1:0] wr_idx;
    logic             dma_filled, space_q;
    flag_evt_t        sticky_evt  [N_STICKY];
    logic             sticky_flag [N_STICKY];

    spi_txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_valid),
        .pop_req  (load_req),
        .flush    (flush),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .wr_idx   (wr_idx),
        .rd_idx   (next_slot),
        .count    (level),
        .full     (full),
        .empty    (empty)
    );

    spi_txq_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .wr_en   (push_ok),
        .wr_idx  (wr_idx),
        .wr_data (push_data),
        .rd_idx  (next_slot),
        .rd_data (load_data)
    );

    // A DMA push that takes the last free slot ends the fill request
    always_comb dma_filled = push_ok && push_from_dma && !pop_ok && (level == LAST_FREE);

    // Space flag: re-armed whenever not full, cleared by DMA fill or write-1
    always_ff @(posedge clk) begin
        if (!rst_n)                       space_q <= 1'b1;
        else if (space_clr || dma_filled) space_q <= 1'b0;
        else if (!full)                   space_q <= 1'b1;
    end

    // Event wiring for the two sticky flags: index 0 done, index 1 underrun
    always_comb begin
        sticky_evt[0].set = xfer_done;
        sticky_evt[0].clr = done_clr;
        sticky_evt[1].set = slave_mode && ext_start && empty;
        sticky_evt[1].clr = underrun_clr;
    end

    for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
        spi_txq_w1c_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (sticky_evt[g]),
            .flag  (sticky_flag[g])
        );
    end

    // Output fan-out
    always_comb begin
        entry_avail   = !empty;
        space_flag    = space_q;
        space_req     = space_q;
        done_flag     = sticky_flag[0];
        underrun_flag = sticky_flag[1];
    end

    // R7
    space_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full && !space_clr && !(push_valid && push_from_dma) |=> space_flag);

    // R7
    dma_fill_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && push_from_dma && !load_req && !flush && level == LAST_FREE |=> !space_flag);

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !space_flag && !flush |=> !space_flag);

    // R10
    underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode && ext_start && level == '0 |=> underrun_flag);

    // R10
    master_no_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !underrun_flag && !slave_mode |=> !underrun_flag);
endmodule

// File: tb/spi_txq_ctrl_tb.sv
`timescale 1ns/1ps
module spi_txq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_valid, push_from_dma, load_req, xfer_done;
    logic        slave_mode, ext_start, flush, space_clr, done_clr, underrun_clr;
    logic [31:0] push_data, load_data;
    logic        entry_avail, space_flag, space_req, done_flag, underrun_flag;
    logic [2:0]  level;
    logic [1:0]  next_slot;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] model_q [$];
    int          mcnt = 0;

    always #2.5 clk = ~clk;

    spi_txq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_from_dma(push_from_dma),
        .push_data(push_data), .load_req(load_req), .xfer_done(xfer_done),
        .slave_mode(slave_mode), .ext_start(ext_start), .flush(flush),
        .space_clr(space_clr), .done_clr(done_clr), .underrun_clr(underrun_clr),
        .load_data(load_data), .entry_avail(entry_avail), .level(level),
        .next_slot(next_slot), .space_flag(space_flag), .space_req(space_req),
        .done_flag(done_flag), .underrun_flag(underrun_flag)
    );

    // Row: {op = {flush, load, dma, push}, expected level, expected next_slot, expected space_flag}
    localparam int NV = 22;
    localparam logic [9:0] VEC [NV] = '{
        {4'b0001, 3'd1, 2'd0, 1'b1},
        {4'b0001, 3'd2, 2'd0, 1'b1},
        {4'b0100, 3'd1, 2'd1, 1'b1},
        {4'b0001, 3'd2, 2'd1, 1'b1},
        {4'b0001, 3'd3, 2'd1, 1'b1},
        {4'b0011, 3'd4, 2'd1, 1'b0},
        {4'b0001, 3'd4, 2'd1, 1'b0},
        {4'b0101, 3'd3, 2'd2, 1'b0},
        {4'b0000, 3'd3, 2'd2, 1'b1},
        {4'b0101, 3'd3, 2'd3, 1'b1},
        {4'b0100, 3'd2, 2'd0, 1'b1},
        {4'b0100, 3'd1, 2'd1, 1'b1},
        {4'b0100, 3'd0, 2'd2, 1'b1},
        {4'b0100, 3'd0, 2'd2, 1'b1},
        {4'b0001, 3'd1, 2'd2, 1'b1},
        {4'b1001, 3'd0, 2'd0, 1'b1},
        {4'b0001, 3'd1, 2'd0, 1'b1},
        {4'b0001, 3'd2, 2'd0, 1'b1},
        {4'b0001, 3'd3, 2'd0, 1'b1},
        {4'b0001, 3'd4, 2'd0, 1'b1},
        {4'b0011, 3'd4, 2'd0, 1'b1},
        {4'b1000, 3'd0, 2'd0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        push_valid = 0; push_from_dma = 0; load_req = 0; xfer_done = 0;
        ext_start = 0; flush = 0; space_clr = 0; done_clr = 0; underrun_clr = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        slave_mode = 0; push_data = '0; rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        // R1 reset state
        chk("R1 level", level, 0);
        chk("R1 next_slot", next_slot, 0);
        chk("R1 entry_avail", entry_avail, 0);
        chk("R1 space_flag", space_flag, 1);
        chk("R1 done_flag", done_flag, 0);
        chk("R1 underrun_flag", underrun_flag, 0);

        // Vector table: R2 R3 R4 R5 R6 R7 R11
        for (int i = 0; i < NV; i++) begin
            logic [3:0] op;
            logic acc_push, acc_load;
            op = VEC[i][9:6];
            push_valid = op[0]; push_from_dma = op[1]; load_req = op[2]; flush = op[3];
            push_data = 32'hA500_0000 + 32'(i);
            acc_push = op[0] && !op[3] && (mcnt < 4);
            acc_load = op[2] && !op[3] && (mcnt > 0);
            if (acc_load) chk("R2 load_data order", load_data, model_q[0]);
            tick();
            if (op[3]) begin
                model_q.delete();
                mcnt = 0;
            end else begin
                if (acc_load) begin void'(model_q.pop_front()); mcnt--; end
                if (acc_push) begin model_q.push_back(32'hA500_0000 + 32'(i)); mcnt++; end
            end
            idle_inputs();
            chk("R2 R4 R5 R6 R11 level", level, 32'(VEC[i][5:3]));
            chk("R3 R6 next_slot", next_slot, 32'(VEC[i][2:1]));
            chk("R7 space_flag", space_flag, 32'(VEC[i][0]));
            chk("R3 entry_avail", entry_avail, 32'(mcnt != 0));
        end

        // R8 clear while not full: drops one edge, re-arms the next
        space_clr = 1; tick(); space_clr = 0;
        chk("R8 clr not full", space_flag, 0);
        chk("R8 space_req follows", space_req, 0);
        tick();
        chk("R8 re-arm", space_flag, 1);
        chk("R8 space_req follows", space_req, 1);

        // R8 clear while full: stays low until room appears
        for (int k = 0; k < 4; k++) begin
            push_valid = 1; push_data = 32'hC0DE_0000 + 32'(k); tick();
        end
        push_valid = 0;
        chk("R7 host fill keeps flag", space_flag, 1);
        space_clr = 1; tick(); space_clr = 0;
        chk("R8 clr full", space_flag, 0);
        tick();
        chk("R8 full holds clear", space_flag, 0);
        chk("R2 head after refill", load_data, 32'hC0DE_0000);
        load_req = 1; tick(); load_req = 0;
        chk("R8 still low at load edge", space_flag, 0);
        tick();
        chk("R8 re-arm after load", space_flag, 1);
        flush = 1; tick(); flush = 0;
        chk("R6 flush level", level, 0);

        // R9 transfer-complete flag
        xfer_done = 1; tick(); xfer_done = 0;
        chk("R9 set", done_flag, 1);
        tick();
        chk("R9 sticky", done_flag, 1);
        done_clr = 1; tick(); done_clr = 0;
        chk("R9 clear", done_flag, 0);
        done_clr = 1; xfer_done = 1; tick(); idle_inputs();
        chk("R9 set wins", done_flag, 1);

        // R10 underflow flag
        ext_start = 1; slave_mode = 0; tick(); ext_start = 0;
        chk("R10 master no set", underrun_flag, 0);
        push_valid = 1; tick(); push_valid = 0;
        slave_mode = 1; ext_start = 1; tick(); ext_start = 0;
        chk("R10 non-empty no set", underrun_flag, 0);
        flush = 1; tick(); flush = 0;
        ext_start = 1; tick(); ext_start = 0;
        chk("R10 empty slave set", underrun_flag, 1);
        tick();
        chk("R10 sticky", underrun_flag, 1);
        underrun_clr = 1; tick(); underrun_clr = 0;
        chk("R10 clear", underrun_flag, 0);
        underrun_clr = 1; ext_start = 1; tick(); idle_inputs();
        chk("R10 set wins", underrun_flag, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule